// File: doc/BRIEF.md
# DMA Control and Status Register Bank

This block is the software-visible register bank of a network DMA controller. It sits on a word-addressed host bus and holds the control word, the interrupt enable mask, the bus mode word, the base addresses of the receive and transmit descriptor lists, and the two current descriptor pointers. It also holds an event status register. Its bits are set by one-cycle strobes from the transmit and receive engines, and software clears them by writing ones. A single level interrupt is raised whenever a status bit is set and enabled.

Toward the engines the block drives a receive enable level, a transmit start level, a one-cycle transmit poll pulse, and the two current descriptor pointers. The host request is a valid-qualified command that the block always accepts in the cycle it is presented, so there is no back-pressure. A read returns its data with a companion valid flag exactly one cycle later. One command (read or write) is carried per cycle.

Word map (word index = byte address shifted right by two): 0 version, 1 control, 2 status, 3 interrupt enable, 4 bus mode, 5 transmit poll, 6 receive list base, 7 transmit list base, 8 current receive pointer, 9 current transmit pointer.

Top module: `dma_csr_regs`

## Requirements
- R1: After reset every stored register reads zero, `irq`, `rx_enable`, `tx_go`, `tx_poll` and `rd_valid` are low, and both descriptor pointers are zero.
- R2: The word index is `req_addr` shifted right by two; the two low address bits have no effect on which register is accessed.
- R3: A write to status (index 2) clears exactly the bits written as one and leaves every other bit unchanged.
- R4: `ev_tx_done` sets status bits 0 and 16; `ev_rx_done` sets bits 6 and 16; `ev_rx_nobuf` sets bits 7 and 15. The bits are visible from the cycle after the strobe.
- R5: When an event strobe and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R6: `irq` is high exactly when the AND of status and interrupt enable (index 3) is nonzero, and it follows each write and event from the next cycle.
- R7: Writing the receive list base (index 6) loads the same value into the current receive pointer, and writing the transmit list base (index 7) does the same for the transmit pointer. Writing index 8 or 9 loads that pointer alone and leaves the base unchanged.
- R8: Bus mode (index 4) stores the written value with bit 0 forced to zero.
- R9: A read of index 0 returns 0x00001012, and writes to it have no effect.
- R10: A write to index 5 stores nothing (index 5 reads zero) and drives `tx_poll` high for exactly the next cycle.
- R11: `rx_enable` follows control bit 1 and `tx_go` follows control bit 13, from the cycle after the control write.
- R12: Reads of indices 10 and above return zero, and writes to them change no register or output.
- R13: A read request produces `rd_valid` high with the data in the following cycle. The data is the register value before any update in the request cycle. `rd_data` is zero whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host command present; always accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data, zero when not valid |
| ev_tx_done | input | 1 | Transmit frame completed strobe |
| ev_rx_done | input | 1 | Receive frame completed strobe |
| ev_rx_nobuf | input | 1 | Receive descriptor unavailable strobe |
| irq | output | 1 | Level interrupt |
| rx_enable | output | 1 | Receive engine enable |
| tx_go | output | 1 | Transmit engine start flag |
| tx_poll | output | 1 | One-cycle transmit poll pulse |
| rx_desc_ptr | output | 32 | Current receive descriptor pointer |
| tx_desc_ptr | output | 32 | Current transmit descriptor pointer |

## Verification
The status logic is tried with lone event strobes, with clearing writes that hit only some of the set bits, and with a strobe that lands on a bit in the same cycle as its clear. Together these separate set-only, clear-only and set-wins behaviour. The pointers are driven first through base writes and then through direct pointer writes, which shows whether a base write reloads its pointer and whether a pointer write leaves the base alone. A long random phase mixes all indices, including unmapped ones and the low address bits, with random strobes. A reference model compares every output on every clock, which exposes ordering errors between a read and a same-cycle update.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int DATA_W = 32;
  localparam int NUM_EV = 3;
  localparam int IDX_W  = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_VERSION = 4'd0,
    IDX_CTRL    = 4'd1,
    IDX_STATUS  = 4'd2,
    IDX_IEN     = 4'd3,
    IDX_BUSMODE = 4'd4,
    IDX_TXPOLL  = 4'd5,
    IDX_RXBASE  = 4'd6,
    IDX_TXBASE  = 4'd7,
    IDX_RXCUR   = 4'd8,
    IDX_TXCUR   = 4'd9
  } reg_idx_e;

  localparam int LAST_IDX = 9;

  localparam logic [DATA_W-1:0] VERSION_ID = 32'h0000_1012;

  // status bit positions
  localparam int ST_TX_DONE  = 0;
  localparam int ST_RX_DONE  = 6;
  localparam int ST_RX_NOBUF = 7;
  localparam int ST_ABNORMAL = 15;
  localparam int ST_NORMAL   = 16;

  // control and bus mode bit positions
  localparam int CTL_RX_EN   = 1;
  localparam int CTL_TX_GO   = 13;
  localparam int BM_SOFT_RST = 0;

  // event order in the strobe vector
  localparam int EV_TX_DONE  = 0;
  localparam int EV_RX_DONE  = 1;
  localparam int EV_RX_NOBUF = 2;

  typedef struct packed {
    logic ctrl;
    logic status;
    logic ien;
    logic busmode;
    logic txpoll;
    logic rxbase;
    logic txbase;
    logic rxcur;
    logic txcur;
  } wr_strobe_t;

  function automatic logic [DATA_W-1:0] ev_set_mask(input int ev);
    logic [DATA_W-1:0] m;
    m = '0;
    case (ev)
      EV_TX_DONE: begin
        m[ST_TX_DONE] = 1'b1;
        m[ST_NORMAL]  = 1'b1;
      end
      EV_RX_DONE: begin
        m[ST_RX_DONE] = 1'b1;
        m[ST_NORMAL]  = 1'b1;
      end
      EV_RX_NOBUF: begin
        m[ST_RX_NOBUF] = 1'b1;
        m[ST_ABNORMAL] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output wr_strobe_t        wr,
  output logic              rd_req,
  output logic              rd_mapped,
  output reg_idx_e          rd_sel
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              mapped;
  logic              do_wr;
  reg_idx_e          sel;
  logic              unused_lo;

  assign word      = req_addr[ADDR_W-1:2];
  assign unused_lo = ^req_addr[1:0];
  assign mapped    = (word <= WORD_W'(LAST_IDX));
  assign sel       = reg_idx_e'(word[IDX_W-1:0]);
  assign do_wr     = req_valid && req_we && mapped;

  assign rd_req    = req_valid && !req_we;
  assign rd_mapped = mapped;
  assign rd_sel    = sel;

  always_comb begin
    wr = '0;
    if (do_wr) begin
      case (sel)
        IDX_CTRL:    wr.ctrl    = 1'b1;
        IDX_STATUS:  wr.status  = 1'b1;
        IDX_IEN:     wr.ien     = 1'b1;
        IDX_BUSMODE: wr.busmode = 1'b1;
        IDX_TXPOLL:  wr.txpoll  = 1'b1;
        IDX_RXBASE:  wr.rxbase  = 1'b1;
        IDX_TXBASE:  wr.txbase  = 1'b1;
        IDX_RXCUR:   wr.rxcur   = 1'b1;
        IDX_TXCUR:   wr.txcur   = 1'b1;
        default:     wr = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
  import dma_csr_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int NEV = NUM_EV
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev,
  input  logic           clr_we,
  input  logic [W-1:0]   clr_mask,
  output logic [W-1:0]   status_q
);

  logic [W-1:0] set_v;

  always_comb begin
    set_v = '0;
    for (int e = 0; e < NEV; e++) begin
      if (ev[e]) set_v = set_v | W'(ev_set_mask(e));
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[b] <= 1'b0;
      end else if (set_v[b]) begin
        status_q[b] <= 1'b1;
      end else if (clr_we && clr_mask[b]) begin
        status_q[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_csr_ptr.sv
module dma_csr_ptr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         base_we,
  input  logic         cur_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] base_q,
  output logic [W-1:0] cur_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (base_we) begin
      base_q <= wdata;
      cur_q  <= wdata;
    end else if (cur_we) begin
      cur_q  <= wdata;
    end
  end

endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_rx_nobuf,
  output logic              irq,
  output logic              rx_enable,
  output logic              tx_go,
  output logic              tx_poll,
  output logic [DATA_W-1:0] rx_desc_ptr,
  output logic [DATA_W-1:0] tx_desc_ptr
);

  localparam int NUM_CH = 2;
  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;

  wr_strobe_t        wr;
  logic              rd_req;
  logic              rd_mapped;
  reg_idx_e          rd_sel;
  logic [NUM_EV-1:0] ev_vec;

  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] ien_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] busmode_q;
  logic              tx_poll_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [DATA_W-1:0] rd_mux;

  logic [NUM_CH-1:0] base_we;
  logic [NUM_CH-1:0] cur_we;
  logic [DATA_W-1:0] base_q [NUM_CH];
  logic [DATA_W-1:0] cur_q  [NUM_CH];

  dma_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .wr        (wr),
    .rd_req    (rd_req),
    .rd_mapped (rd_mapped),
    .rd_sel    (rd_sel)
  );

  always_comb begin
    ev_vec              = '0;
    ev_vec[EV_TX_DONE]  = ev_tx_done;
    ev_vec[EV_RX_DONE]  = ev_rx_done;
    ev_vec[EV_RX_NOBUF] = ev_rx_nobuf;
  end

  dma_csr_status #(.W(DATA_W), .NEV(NUM_EV)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_vec),
    .clr_we   (wr.status),
    .clr_mask (req_wdata),
    .status_q (status_q)
  );

  assign base_we[CH_RX] = wr.rxbase;
  assign base_we[CH_TX] = wr.txbase;
  assign cur_we[CH_RX]  = wr.rxcur;
  assign cur_we[CH_TX]  = wr.txcur;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_csr_ptr #(.W(DATA_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_we (base_we[c]),
      .cur_we  (cur_we[c]),
      .wdata   (req_wdata),
      .base_q  (base_q[c]),
      .cur_q   (cur_q[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ien_q     <= '0;
      busmode_q <= '0;
      tx_poll_q <= 1'b0;
    end else begin
      if (wr.ctrl) ctrl_q <= req_wdata;
      if (wr.ien)  ien_q  <= req_wdata;
      if (wr.busmode) begin
        busmode_q              <= req_wdata;
        busmode_q[BM_SOFT_RST] <= 1'b0;
      end
      tx_poll_q <= wr.txpoll;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_mapped) begin
      case (rd_sel)
        IDX_VERSION: rd_mux = VERSION_ID;
        IDX_CTRL:    rd_mux = ctrl_q;
        IDX_STATUS:  rd_mux = status_q;
        IDX_IEN:     rd_mux = ien_q;
        IDX_BUSMODE: rd_mux = busmode_q;
        IDX_TXPOLL:  rd_mux = '0;
        IDX_RXBASE:  rd_mux = base_q[CH_RX];
        IDX_TXBASE:  rd_mux = base_q[CH_TX];
        IDX_RXCUR:   rd_mux = cur_q[CH_RX];
        IDX_TXCUR:   rd_mux = cur_q[CH_TX];
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req;
      rd_data_q  <= rd_req ? rd_mux : '0;
    end
  end

  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign irq         = |(status_q & ien_q);
  assign rx_enable   = ctrl_q[CTL_RX_EN];
  assign tx_go       = ctrl_q[CTL_TX_GO];
  assign tx_poll     = tx_poll_q;
  assign rx_desc_ptr = cur_q[CH_RX];
  assign tx_desc_ptr = cur_q[CH_TX];

endmodule

// File: rtl/dma_csr_checker.sv
module dma_csr_checker
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              ev_tx_done,
  input logic              ev_rx_done,
  input logic              ev_rx_nobuf,
  input logic              irq,
  input logic              tx_poll,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] rx_desc_ptr,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] ien_q
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              any_ev;
  logic              any_wr;
  logic              unused_lo;

  assign word      = req_addr[ADDR_W-1:2];
  assign unused_lo = ^req_addr[1:0];
  assign any_ev    = ev_tx_done || ev_rx_done || ev_rx_nobuf;
  assign any_wr    = req_valid && req_we;

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && word == WORD_W'(IDX_STATUS) && !any_ev)
    |=> status_q == ($past(status_q) & ~$past(req_wdata)));

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done && any_wr && word == WORD_W'(IDX_STATUS) && req_wdata[ST_RX_DONE])
    |=> status_q[ST_RX_DONE]);

  // R6
  irq_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done && ien_q[ST_TX_DONE] && !any_wr) |=> irq);

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R7
  rx_base_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && word == WORD_W'(IDX_RXBASE)) |=> rx_desc_ptr == $past(req_wdata));

  // R10
  poll_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> $past(any_wr && word == WORD_W'(IDX_TXPOLL)));

  // R13
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rd_valid);

  // R9
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && word == WORD_W'(IDX_VERSION)) |=> rd_data == VERSION_ID);

endmodule

bind dma_csr_regs dma_csr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_we      (req_we),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .ev_tx_done  (ev_tx_done),
  .ev_rx_done  (ev_rx_done),
  .ev_rx_nobuf (ev_rx_nobuf),
  .irq         (irq),
  .tx_poll     (tx_poll),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .rx_desc_ptr (rx_desc_ptr),
  .status_q    (status_q),
  .ien_q       (ien_q)
);

// File: tb/tb_dma_csr_regs.sv
module tb_dma_csr_regs;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          ev_tx_done = 1'b0;
  logic          ev_rx_done = 1'b0;
  logic          ev_rx_nobuf = 1'b0;
  logic          rd_valid, irq, rx_enable, tx_go, tx_poll;
  logic [31:0]   rd_data, rx_desc_ptr, tx_desc_ptr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_csr_regs #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_rx_nobuf(ev_rx_nobuf),
    .irq(irq), .rx_enable(rx_enable), .tx_go(tx_go), .tx_poll(tx_poll),
    .rx_desc_ptr(rx_desc_ptr), .tx_desc_ptr(tx_desc_ptr)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_st, m_ien, m_ctl, m_bm, m_rxb, m_txb, m_rxc, m_txc, m_rd;
  logic        m_poll, m_rv;

  function automatic logic [31:0] m_read(input int idx);
    case (idx)
      0: return 32'h0000_1012;
      1: return m_ctl;
      2: return m_st;
      3: return m_ien;
      4: return m_bm;
      6: return m_rxb;
      7: return m_txb;
      8: return m_rxc;
      9: return m_txc;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] setm;
    int idx;
    if (!rst_n) begin
      m_st = 0; m_ien = 0; m_ctl = 0; m_bm = 0; m_rxb = 0; m_txb = 0;
      m_rxc = 0; m_txc = 0; m_rd = 0; m_poll = 0; m_rv = 0;
    end else begin
      idx = int'(req_addr) / 4;
      setm = 0;
      if (ev_tx_done)  setm = setm | 32'h0001_0001;
      if (ev_rx_done)  setm = setm | 32'h0001_0040;
      if (ev_rx_nobuf) setm = setm | 32'h0000_8080;
      m_rv = req_valid && !req_we;
      m_rd = m_rv ? m_read(idx) : 32'h0;
      m_poll = 0;
      if (req_valid && req_we) begin
        case (idx)
          1: m_ctl = req_wdata;
          2: m_st = m_st & ~req_wdata;
          3: m_ien = req_wdata;
          4: m_bm = req_wdata & 32'hFFFF_FFFE;
          5: m_poll = 1;
          6: begin m_rxb = req_wdata; m_rxc = req_wdata; end
          7: begin m_txb = req_wdata; m_txc = req_wdata; end
          8: m_rxc = req_wdata;
          9: m_txc = req_wdata;
          default: ;
        endcase
      end
      m_st = m_st | setm;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 irq", 32'(irq), 32'(|(m_st & m_ien)));
      chk("R11 rx_enable", 32'(rx_enable), 32'(m_ctl[1]));
      chk("R11 tx_go", 32'(tx_go), 32'(m_ctl[13]));
      chk("R10 tx_poll", 32'(tx_poll), 32'(m_poll));
      chk("R7 rx_desc_ptr", rx_desc_ptr, m_rxc);
      chk("R7 tx_desc_ptr", tx_desc_ptr, m_txc);
      chk("R13 rd_valid", 32'(rd_valid), 32'(m_rv));
      chk("R13 rd_data", rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int idx, input logic [31:0] d, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = {4'(idx), lo}; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag,
                    input logic [1:0] lo = 2'b00);
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = {4'(idx), lo};
    @(negedge clk);
    req_valid = 0;
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse(input bit t, input bit r, input bit n);
    @(negedge clk);
    ev_tx_done = t; ev_rx_done = r; ev_rx_nobuf = n;
    @(negedge clk);
    ev_tx_done = 0; ev_rx_done = 0; ev_rx_nobuf = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 tx_poll", 32'(tx_poll), 0);
    rst_n = 1;
    for (int i = 1; i < 10; i++) rd(i, 0, "R1 reg zero");
    chk("R1 rx_desc_ptr", rx_desc_ptr, 0);

    // R9
    rd(0, 32'h0000_1012, "R9 version");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0000_1012, "R9 version after write");

    // R11
    wr(1, 32'h0000_2002);
    chk("R11 rx_enable", 32'(rx_enable), 1);
    chk("R11 tx_go", 32'(tx_go), 1);
    wr(1, 32'h0000_2000);
    chk("R11 rx_enable off", 32'(rx_enable), 0);

    // R8
    wr(4, 32'hABCD_0003);
    rd(4, 32'hABCD_0002, "R8 bus mode bit0");

    // R4
    pulse(1, 0, 0);
    rd(2, 32'h0001_0001, "R4 tx done");
    pulse(0, 1, 0);
    rd(2, 32'h0001_0041, "R4 rx done");
    pulse(0, 0, 1);
    rd(2, 32'h0001_80C1, "R4 rx nobuf");

    // R3
    wr(2, 32'h0000_0041);
    rd(2, 32'h0001_8080, "R3 w1c partial");

    // R5: set and clear on bit 6 in the same cycle
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = {4'd2, 2'b00}; req_wdata = 32'h0000_0040;
    ev_rx_done = 1;
    @(negedge clk);
    req_valid = 0; req_we = 0; ev_rx_done = 0;
    rd(2, 32'h0001_80C0, "R5 set wins");

    // R6
    chk("R6 irq masked", 32'(irq), 0);
    wr(3, 32'h0000_0080);
    chk("R6 irq enabled", 32'(irq), 1);
    wr(2, 32'h0000_0080);
    chk("R6 irq after clear", 32'(irq), 0);
    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'h0, "R3 clear all");

    // R2: low address bits ignored
    wr(1, 32'h0000_0002, 2'b11);
    chk("R2 rx_enable", 32'(rx_enable), 1);
    rd(1, 32'h0000_0002, "R2 read offset", 2'b01);

    // R7
    wr(6, 32'h0000_1000);
    chk("R7 rx reload", rx_desc_ptr, 32'h0000_1000);
    wr(8, 32'h0000_1040);
    chk("R7 rx cur", rx_desc_ptr, 32'h0000_1040);
    rd(6, 32'h0000_1000, "R7 rx base kept");
    wr(7, 32'h0000_2000);
    chk("R7 tx reload", tx_desc_ptr, 32'h0000_2000);
    wr(9, 32'h0000_2020);
    rd(7, 32'h0000_2000, "R7 tx base kept");

    // R10
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = {4'd5, 2'b00}; req_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    chk("R10 poll pulse", 32'(tx_poll), 1);
    @(negedge clk);
    chk("R10 poll one cycle", 32'(tx_poll), 0);
    rd(5, 32'h0, "R10 poll stores nothing");

    // R12
    wr(12, 32'h1234_5678);
    rd(12, 32'h0, "R12 unmapped read");
    rd(1, 32'h0000_0002, "R12 ctrl untouched");
    rd(9, 32'h0000_2020, "R12 tx ptr untouched");

    // random phase, checked by the model every clock (R13 and all others)
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      req_valid   = ($urandom_range(0, 3) != 0);
      req_we      = $urandom_range(0, 1) == 1;
      req_addr    = AW'($urandom_range(0, 63));
      req_wdata   = $urandom;
      ev_tx_done  = ($urandom_range(0, 7) == 0);
      ev_rx_done  = ($urandom_range(0, 7) == 0);
      ev_rx_nobuf = ($urandom_range(0, 9) == 0);
    end
    @(negedge clk);
    req_valid = 0; req_we = 0; ev_tx_done = 0; ev_rx_done = 0; ev_rx_nobuf = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule